// File: doc/BRIEF.md
# Configurable Serial Baud Rate Generator

This block supplies the timing enables for a serial port. A down-counter divides the system clock by a programmed divisor plus one. The divisor is written as a high byte and a low byte. Each time the counter wraps it produces a one-cycle divider tick. In asynchronous operation that tick is presented as the oversampling enable for the transmitter and receiver.

A second counter groups divider ticks into spans of 4, 16 or 64 and emits a one-cycle bit tick at the end of each span. Three mode controls pick the span length: synchronous select, high-speed select and wide-counter select. The wide-counter select also chooses whether the divisor is the full 16-bit value or only its low byte.

Software may rewrite the divisor at any time. A write strobe restarts both counters, so the new rate governs the very next period.

Top module: `baud_rate_gen`

## Requirements
- R1: In asynchronous mode, `os_tick` is high for one cycle every N+1 clock cycles, where N is the active divisor.
- R2: With `wide_cnt` low, N equals `div_lo` and the value on `div_hi` has no effect on either tick. With `wide_cnt` high, N equals {`div_hi`,`div_lo`}.
- R3: With `sync_mode` high, `bit_tick` fires every 4*(N+1) cycles, whatever the values of `high_speed` and `wide_cnt`.
- R4: In asynchronous mode with `high_speed` and `wide_cnt` both high, `bit_tick` fires every 4*(N+1) cycles.
- R5: In asynchronous mode with exactly one of `high_speed` and `wide_cnt` high, `bit_tick` fires every 16*(N+1) cycles.
- R6: In asynchronous mode with `high_speed` and `wide_cnt` both low, `bit_tick` fires every 64*(N+1) cycles.
- R7: With `sync_mode` high, `os_tick` stays low.
- R8: When `div_wr` is sampled high at a clock edge, both counters restart. No tick appears in the following cycle. The first divider tick comes N+1 cycles after that edge, and the first `bit_tick` comes M*(N+1) cycles after it, where M is the span length.
- R9: A divisor of zero makes the divider tick on every clock cycle.
- R10: While `rst_n` is low at a clock edge, both tick outputs are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| div_wr | input | 1 | Divisor write strobe; restarts both counters |
| sync_mode | input | 1 | Synchronous select |
| high_speed | input | 1 | High-speed select |
| wide_cnt | input | 1 | 16-bit counter select |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| os_tick | output | 1 | One-cycle oversampling pulse, asynchronous mode only |

## Verification
The bench walks all eight combinations of the mode controls against several small divisors, including zero. For each run it measures the delay from the write to the first tick and the spacing between ticks. A wrong entry in the multiplier table shows up as a bit period off by a factor of 4 or 16. An off-by-one in the reload shows up as a period of N or N+2 cycles. A divisor of zero catches a divider that stalls or skips when its reload value equals its terminal count.

Some runs drive a nonzero high byte while the counter is 8 bits wide; a mux that leaked that byte would stretch the period by hundreds of cycles. One run rewrites the divisor in the middle of a long period. A design that let the stale count run out would deliver its first tick far too late.

// File: rtl/brg_pkg.sv
// Package brg_pkg
// Shared types and helpers for the baud rate generator: the span length
// selection and the width of the span counter. Assumes the largest span is
// a power of two.
package brg_pkg;

    localparam int unsigned SPAN_MAX = 64;
    localparam int unsigned SPAN_W   = $clog2(SPAN_MAX);

    // One-hot code of the divider periods per bit
    typedef enum logic [2:0] {
        MUL4  = 3'b001,
        MUL16 = 3'b010,
        MUL64 = 3'b100
    } mult_e;

    // Map the three mode controls onto a span length
    function automatic mult_e pick_mult(input logic sync_sel,
                                        input logic fast_sel,
                                        input logic wide_sel);
        mult_e m;
        if (sync_sel)
            m = MUL4;
        else if (fast_sel && wide_sel)
            m = MUL4;
        else if (fast_sel ^ wide_sel)
            m = MUL16;
        else
            m = MUL64;
        return m;
    endfunction

    // Terminal value of the span counter (span length minus one)
    function automatic logic [SPAN_W-1:0] span_last(input mult_e m);
        logic [SPAN_W-1:0] v;
        case (m)
            MUL4:    v = SPAN_W'(3);
            MUL16:   v = SPAN_W'(15);
            default: v = SPAN_W'(SPAN_MAX - 1);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/brg_mode_sel.sv
// Module brg_mode_sel
// Forms the active divisor from the two divisor bytes and decodes the mode
// controls into a span length. Purely combinational; the clock and reset
// serve only the embedded checks. Assumes DIV_W is even.
module brg_mode_sel
    import brg_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W/2-1:0]    byte_hi,
    input  logic [DIV_W/2-1:0]    byte_lo,
    input  logic                  sync_sel,
    input  logic                  fast_sel,
    input  logic                  wide_sel,
    output logic [DIV_W-1:0]      div_val,
    output mult_e                 mult,
    output logic [SPAN_W-1:0]     span_end
);

    localparam int unsigned HALF_W = DIV_W / 2;

    // Select the full divisor or only its low byte
    always_comb begin
        if (wide_sel)
            div_val = {byte_hi, byte_lo};
        else
            div_val = {{HALF_W{1'b0}}, byte_lo};
    end

    // Decode the span length and its terminal count
    always_comb begin
        mult     = pick_mult(sync_sel, fast_sel, wide_sel);
        span_end = span_last(mult);
    end

    AST_NARROW_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_sel |-> (div_val[DIV_W-1:HALF_W] == '0 && div_val[HALF_W-1:0] == byte_lo)); // R2
    AST_SYNC_X4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel |-> (mult == MUL4 && span_end == SPAN_W'(3))); // R3
    AST_FAST_WIDE_X4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_sel && fast_sel && wide_sel) |-> (mult == MUL4)); // R4
    AST_ONE_SET_X16: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_sel && (fast_sel != wide_sel)) |-> (mult == MUL16)); // R5
    AST_SLOW_X64: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_sel && !fast_sel && !wide_sel) |-> (mult == MUL64)); // R6

endmodule

// File: rtl/brg_divider.sv
// Module brg_divider
// Down-counter that divides the clock by div_val+1 and registers a
// one-cycle tick on each wrap. A load restarts the count from div_val.
// Assumes div_val is held stable between loads for an exact period.
module brg_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIV_W-1:0]  div_val,
    output logic              tick
);

    logic [DIV_W-1:0] cnt;

    // Count down, reload on wrap or on a divisor write, flag the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (load) begin
            cnt  <= div_val;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= div_val;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end

    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (tick && cnt == $past(div_val))); // R1
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!tick && cnt == $past(div_val))); // R8
    AST_ZERO_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && div_val == '0 && !load) |=> (tick && cnt == '0)); // R9

endmodule

// File: rtl/brg_span.sv
// Module brg_span
// Counts divider ticks and raises bit_tick on the tick that completes a
// span of span_end+1. Wraps safely if span_end shrinks mid-span. A load
// clears the span count.
module brg_span
    import brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [SPAN_W-1:0] span_end,
    output logic              bit_tick
);

    logic [SPAN_W-1:0] scnt;
    logic              at_end;

    // Flag the last divider period of the span
    always_comb begin
        at_end   = (scnt >= span_end);
        bit_tick = step && at_end && !load;
    end

    // Advance the span count on each divider tick, clear on wrap or load
    always_ff @(posedge clk) begin
        if (!rst_n)
            scnt <= '0;
        else if (load)
            scnt <= '0;
        else if (step)
            scnt <= at_end ? '0 : scnt + 1'b1;
    end

    AST_SPAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (scnt == '0)); // R4
    AST_SPAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !bit_tick && !load) |=> (scnt == $past(scnt) + 1'b1)); // R5
    AST_SPAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (scnt == '0)); // R8

endmodule

// File: rtl/baud_rate_gen.sv
// Module baud_rate_gen
// Top of the baud rate generator: divisor selection and mode decode, the
// clock divider, and the span counter that turns divider ticks into bit
// ticks. The oversampling tick is passed out in asynchronous mode only.
// Assumes mode controls change only together with a divisor write.
module baud_rate_gen
    import brg_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W/2-1:0] div_hi,
    input  logic [DIV_W/2-1:0] div_lo,
    input  logic               div_wr,
    input  logic               sync_mode,
    input  logic               high_speed,
    input  logic               wide_cnt,
    output logic               bit_tick,
    output logic               os_tick
);

    logic [DIV_W-1:0]  div_val;
    mult_e             mult;
    logic [SPAN_W-1:0] span_end;
    logic              div_tick;

    brg_mode_sel #(.DIV_W(DIV_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_hi  (div_hi),
        .byte_lo  (div_lo),
        .sync_sel (sync_mode),
        .fast_sel (high_speed),
        .wide_sel (wide_cnt),
        .div_val  (div_val),
        .mult     (mult),
        .span_end (span_end)
    );

    brg_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (div_wr),
        .div_val (div_val),
        .tick    (div_tick)
    );

    brg_span u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_wr),
        .step     (div_tick),
        .span_end (span_end),
        .bit_tick (bit_tick)
    );

    // Expose the divider tick as the oversampling enable in asynchronous mode
    always_comb os_tick = div_tick && !sync_mode;

    AST_SYNC_NO_OS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> !os_tick); // R7
    AST_BIT_ON_DIV_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> div_tick); // R1
    AST_ONE_HOT_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mult) && (mult != 3'b000)); // R6

endmodule

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_hi = 8'h00;
    logic [7:0] div_lo = 8'h00;
    logic       div_wr = 1'b0;
    logic       sync_mode = 1'b0;
    logic       high_speed = 1'b0;
    logic       wide_cnt = 1'b0;
    logic       bit_tick;
    logic       os_tick;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_rate_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_hi     (div_hi),
        .div_lo     (div_lo),
        .div_wr     (div_wr),
        .sync_mode  (sync_mode),
        .high_speed (high_speed),
        .wide_cnt   (wide_cnt),
        .bit_tick   (bit_tick),
        .os_tick    (os_tick)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write a divisor and mode, then measure tick timing over two bit periods
    task automatic run_cfg(input logic [7:0] hi, input logic [7:0] lo,
                           input logic s, input logic hs, input logic w);
        int n;
        int m;
        int p;
        int os1;
        int os2;
        int os_cnt;
        int bt1;
        int bt2;
        int early;
        string rq_bit;
        string rq_os;
        n = w ? int'({hi, lo}) : int'(lo);
        if (s)            begin m = 4;  rq_bit = "R3"; end
        else if (hs && w) begin m = 4;  rq_bit = "R4"; end
        else if (hs ^ w)  begin m = 16; rq_bit = "R5"; end
        else              begin m = 64; rq_bit = "R6"; end
        if (!w && hi != 8'h00) rq_os = "R2";
        else if (n == 0)       rq_os = "R9";
        else                   rq_os = "R1";
        p = (n + 1) * m;
        os1 = -1; os2 = -1; bt1 = -1; bt2 = -1; os_cnt = 0; early = 0;
        div_hi = hi; div_lo = lo; sync_mode = s; high_speed = hs; wide_cnt = w;
        div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        // k = 0 is the cycle right after the write edge
        if (bit_tick || os_tick) early = 1;
        for (int k = 1; k <= 2 * p + 2; k++) begin
            @(negedge clk);
            if (os_tick) begin
                os_cnt++;
                if (os1 < 0) os1 = k;
                else if (os2 < 0) os2 = k;
            end
            if (bit_tick) begin
                if (bt1 < 0) bt1 = k;
                else if (bt2 < 0) bt2 = k;
            end
        end
        check("R8", "tick in cycle after write", early, 0);
        if (s) begin
            check("R7", "os_tick pulses in sync mode", os_cnt, 0);
        end else begin
            check("R8", "first os_tick delay", os1, n + 1);
            check(rq_os, "os_tick period", os2 - os1, n + 1);
        end
        check("R8", "first bit_tick delay", bt1, p);
        check(rq_bit, "bit_tick period", bt2 - bt1, p);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: outputs quiet during reset
        repeat (3) @(negedge clk);
        check("R10", "bit_tick in reset", int'(bit_tick), 0);
        check("R10", "os_tick in reset", int'(os_tick), 0);
        rst_n = 1'b1;

        // Sweep every mode combination across small divisors
        for (int mode = 0; mode < 8; mode++) begin
            for (int di = 0; di < 4; di++) begin
                logic [7:0] lo;
                lo = (di == 0) ? 8'd0 : (di == 1) ? 8'd1 : (di == 2) ? 8'd2 : 8'd5;
                run_cfg(8'h00, lo, mode[2], mode[1], mode[0]);
            end
        end

        // R2: high byte ignored when narrow, used when wide
        run_cfg(8'hFF, 8'd3, 1'b0, 1'b1, 1'b0);
        run_cfg(8'hA5, 8'd0, 1'b0, 1'b0, 1'b0);
        run_cfg(8'h01, 8'd2, 1'b0, 1'b1, 1'b1);
        run_cfg(8'h01, 8'd2, 1'b0, 1'b0, 1'b1);

        // R8: rewrite in the middle of a long period
        div_hi = 8'h00; div_lo = 8'd200; sync_mode = 1'b0;
        high_speed = 1'b0; wide_cnt = 1'b0;
        div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        repeat (57) @(negedge clk);
        run_cfg(8'h00, 8'd1, 1'b0, 1'b1, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule